// File: doc/BRIEF.md
# External Memory Window Controller

This block sits beside a small DSP core and gives it windowed, self-stepping access to external memory. The core owns five window registers. Reading or writing a window produces one request on the external memory interface at an address held for that window and direction. The stored address then moves by a stride chosen by a 16-bit mode word, so a loop that keeps touching the same window walks through memory without any address arithmetic in software. Each window keeps a separate read setting and write setting.

A setting is loaded through a shared programming register using two 16-bit transfers. The first transfer carries the word address and the second carries the mode. The next window access is a dummy access: it takes the pair as that window's setting for the direction of the access and issues no request. The mode selects the stride: none, +1, +32, −16, −128, or a "cell" stride of +1 from an even address and +31 from an odd one. It also selects the target: DRAM, or ROM for the read-only ROM modes. Two write modes perform a nibble-wise merge, where only nibbles whose data is nonzero are written.

The external memories are outside the block. Requests leave through a registered interface that carries a byte address and a per-nibble write enable.

Top module: `xwin_ctl`

## Requirements
- R1: After reset, mem_req and err are 0, ctl_rdata reads 0x0000, and every window setting is cleared to address 0 and mode 0. An access through a cleared window raises err.
- R2: The programming sequencer has three states: IDLE, HAVE_ADDR and ARMED. A control write in IDLE or ARMED stores ctl_wdata as the address and moves to HAVE_ADDR. A control write in HAVE_ADDR stores it as the mode and moves to ARMED. A control read makes the same moves without storing anything. ctl_rdata shows the stored mode in HAVE_ADDR and the stored address in the other two states.
- R3: A window access in ARMED (window_select below 5) copies the stored address and mode into that window's read setting (win_we=0) or write setting (win_we=1) and produces no request. Any window access returns the sequencer to IDLE. An access in HAVE_ADDR is carried out as a normal access.
- R4: Write mode 0x0018 requests without moving the address. Write mode 0x0818 requests and then adds 1.
- R5: Read modes step the address after the request: 0x0018 by 0, 0x0818 by +1, 0x3018 by +32, 0xA818 by −16, 0xB818 by −128. Address arithmetic wraps modulo 2^16.
- R6: A read whose mode has bits 15:4 equal to 0x080 is a ROM read: mem_rom=1, the address steps by +1, and mode bits 3:0 supply word-address bits 19:16.
- R7: Write mode 0x0418 requests without moving the address. Nibble n of mem_nib_en (bits 4n+3:4n) is 1 only when that nibble of the write data is nonzero. All other writes and all reads drive mem_nib_en=0xF.
- R8: Write modes 0x4018 and 0x4418 add 1 when the address is even and 31 when it is odd. Mode 0x4418 also applies the nibble merge of R7.
- R9: The byte address is {mode[6:0], word_address[15:0], 1'b0}. mem_addr bit 0 is therefore always 0.
- R10: Window 4 always uses its setting. Windows 0 to 3 use theirs only when gp_stat is nonzero. Otherwise the access produces no request and leaves the setting unchanged.
- R11: After every access that uses a setting, ctl_rdata (in IDLE) shows that setting's address as it stands after the step.
- R12: A mode not listed above produces no request, leaves the address unchanged and raises err for exactly one cycle.
- R13: The read setting and the write setting of a window are independent. Stepping one leaves the other unchanged.
- R14: Requests and err appear one clock after the window access that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the programming register |
| ctl_rd | input | 1 | Read strobe for the programming register |
| ctl_wdata | input | 16 | Address or mode word being programmed |
| ctl_rdata | output | 16 | Programming register readback |
| win_acc | input | 1 | Window access strobe |
| win_sel | input | 3 | Window number, 0 to 4 |
| win_we | input | 1 | Access direction, 1 = write |
| win_wdata | input | 16 | Write data for the window |
| gp_stat | input | 2 | General-purpose status bits that enable windows 0 to 3 |
| mem_req | output | 1 | External memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_rom | output | 1 | Request targets ROM |
| mem_addr | output | 24 | Byte address of the request |
| mem_wdata | output | 16 | Write data of the request |
| mem_nib_en | output | 4 | Per-nibble write enable |
| err | output | 1 | Unrecognised mode on a used access |

## Verification
A wrong sequencer state shows up at the next window access. The access either produces a request where it should silently take a setting, or it takes a setting where it should produce a request. ctl_rdata also shows mode instead of address, or the reverse, in the same cycle. A wrong stride or a wrong parity decision in the cell modes is visible on mem_addr at the following access through the same window, one clock after that access. It is also visible straight away on ctl_rdata. A merge fault shows on mem_nib_en in the cycle of the request.

// File: rtl/xwin_pkg.sv
package xwin_pkg;

    typedef enum logic [1:0] {
        PRG_IDLE      = 2'd0,
        PRG_HAVE_ADDR = 2'd1,
        PRG_ARMED     = 2'd2
    } prg_state_e;

    // decoded behaviour of one mode word
    typedef struct packed {
        logic        valid;
        logic        rom;
        logic        merge;
        logic [15:0] step;
    } step_t;

endpackage

// File: rtl/xwin_mode_dec.sv
module xwin_mode_dec
    import xwin_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] mode,
    input  logic              addr_odd,
    input  logic              is_write,
    output step_t             dec
);
    localparam logic [15:0] STEP_ZERO = 16'h0000;
    localparam logic [15:0] STEP_INC1 = 16'h0001;

    always_comb begin
        dec = '{valid: 1'b0, rom: 1'b0, merge: 1'b0, step: STEP_ZERO};
        if (is_write) begin
            unique case (mode)
                16'h0018: dec.valid = 1'b1;
                16'h0818: begin dec.valid = 1'b1; dec.step = STEP_INC1; end
                16'h0418: begin dec.valid = 1'b1; dec.merge = 1'b1; end
                16'h4018, 16'h4418: begin
                    dec.valid = 1'b1;
                    dec.merge = mode[10];
                    dec.step  = addr_odd ? 16'd31 : STEP_INC1;
                end
                default: dec.valid = 1'b0;
            endcase
        end else if (mode[15:4] == 12'h080) begin
            dec.valid = 1'b1;
            dec.rom   = 1'b1;
            dec.step  = STEP_INC1;
        end else begin
            unique case (mode)
                16'h0018: dec.valid = 1'b1;
                16'h0818: begin dec.valid = 1'b1; dec.step = STEP_INC1; end
                16'h3018: begin dec.valid = 1'b1; dec.step = 16'd32; end
                16'hA818: begin dec.valid = 1'b1; dec.step = 16'hFFF0; end
                16'hB818: begin dec.valid = 1'b1; dec.step = 16'hFF80; end
                default: dec.valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/xwin_prog_fsm.sv
module xwin_prog_fsm
    import xwin_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              win_acc,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_mode,
    output prg_state_e        state,
    output logic [WORD_W-1:0] pmc_addr,
    output logic [WORD_W-1:0] pmc_mode,
    output logic [WORD_W-1:0] ctl_rdata
);
    prg_state_e state_nxt;
    logic       ctl_any;

    assign ctl_any = ctl_wr || ctl_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PRG_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (win_acc) begin
            state_nxt = PRG_IDLE;
        end else if (ctl_any) begin
            unique case (state)
                PRG_IDLE:      state_nxt = PRG_HAVE_ADDR;
                PRG_HAVE_ADDR: state_nxt = PRG_ARMED;
                PRG_ARMED:     state_nxt = PRG_HAVE_ADDR;
                default:       state_nxt = PRG_IDLE;
            endcase
        end
    end

    // programming register contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmc_addr <= '0;
            pmc_mode <= '0;
        end else if (win_acc) begin
            if (load_en) begin
                pmc_addr <= load_addr;
                pmc_mode <= load_mode;
            end
        end else if (ctl_wr) begin
            if (state == PRG_HAVE_ADDR) pmc_mode <= ctl_wdata;
            else                        pmc_addr <= ctl_wdata;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            PRG_HAVE_ADDR: ctl_rdata = pmc_mode;
            default:       ctl_rdata = pmc_addr;
        endcase
    end
endmodule

// File: rtl/xwin_cfg_store.sv
module xwin_cfg_store #(
    parameter int WORD_W  = 16,
    parameter int NUM_WIN = 5,
    parameter int SEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_en,
    input  logic              step_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic              dir_wr,
    input  logic [WORD_W-1:0] arm_addr,
    input  logic [WORD_W-1:0] arm_mode,
    input  logic [WORD_W-1:0] step_addr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_mode
);
    // index 0 = read setting, 1 = write setting
    logic [WORD_W-1:0] addr_q [NUM_WIN][2];
    logic [WORD_W-1:0] mode_q [NUM_WIN][2];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        for (genvar d = 0; d < 2; d++) begin : g_dir
            logic hit;
            assign hit = (sel == SEL_W'(w)) && (dir_wr == d[0]);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q[w][d] <= '0;
                    mode_q[w][d] <= '0;
                end else if (hit && arm_en) begin
                    addr_q[w][d] <= arm_addr;
                    mode_q[w][d] <= arm_mode;
                end else if (hit && step_en) begin
                    addr_q[w][d] <= step_addr;
                end
            end
        end
    end

    always_comb begin
        cur_addr = '0;
        cur_mode = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (sel == SEL_W'(w)) begin
                cur_addr = addr_q[w][dir_wr];
                cur_mode = mode_q[w][dir_wr];
            end
        end
    end
endmodule

// File: rtl/xwin_ctl.sv
module xwin_ctl
    import xwin_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int NUM_WIN  = 5,
    parameter int PROG_WIN = 4,
    parameter int SEL_W    = 3,
    parameter int HI_W     = 7,
    parameter int GP_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_wr,
    input  logic                      ctl_rd,
    input  logic [WORD_W-1:0]         ctl_wdata,
    output logic [WORD_W-1:0]         ctl_rdata,
    input  logic                      win_acc,
    input  logic [SEL_W-1:0]          win_sel,
    input  logic                      win_we,
    input  logic [WORD_W-1:0]         win_wdata,
    input  logic [GP_W-1:0]           gp_stat,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic                      mem_rom,
    output logic [HI_W+WORD_W:0]      mem_addr,
    output logic [WORD_W-1:0]         mem_wdata,
    output logic [WORD_W/4-1:0]       mem_nib_en,
    output logic                      err
);
    localparam int NIB_N = WORD_W / 4;

    prg_state_e        ctl_state;
    logic [WORD_W-1:0] pmc_addr, pmc_mode;
    logic [WORD_W-1:0] cur_addr, cur_mode, nxt_addr;
    logic              sel_ok, arm_hit, use_hit, step_en;
    step_t             dec;
    logic [NIB_N-1:0]  nib_nz;

    assign sel_ok  = (win_sel < SEL_W'(NUM_WIN));
    assign arm_hit = win_acc && sel_ok && (ctl_state == PRG_ARMED);
    assign use_hit = win_acc && sel_ok && (ctl_state != PRG_ARMED)
                     && ((win_sel == SEL_W'(PROG_WIN)) || (|gp_stat));
    assign step_en = use_hit && dec.valid;
    assign nxt_addr = dec.valid ? (cur_addr + dec.step) : cur_addr;

    xwin_prog_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_rd    (ctl_rd),
        .ctl_wdata (ctl_wdata),
        .win_acc   (win_acc),
        .load_en   (use_hit),
        .load_addr (nxt_addr),
        .load_mode (cur_mode),
        .state     (ctl_state),
        .pmc_addr  (pmc_addr),
        .pmc_mode  (pmc_mode),
        .ctl_rdata (ctl_rdata)
    );

    xwin_cfg_store #(.WORD_W(WORD_W), .NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_en    (arm_hit),
        .step_en   (step_en),
        .sel       (win_sel),
        .dir_wr    (win_we),
        .arm_addr  (pmc_addr),
        .arm_mode  (pmc_mode),
        .step_addr (nxt_addr),
        .cur_addr  (cur_addr),
        .cur_mode  (cur_mode)
    );

    xwin_mode_dec #(.WORD_W(WORD_W)) u_dec (
        .mode     (cur_mode),
        .addr_odd (cur_addr[0]),
        .is_write (win_we),
        .dec      (dec)
    );

    for (genvar n = 0; n < NIB_N; n++) begin : g_nib
        assign nib_nz[n] = |win_wdata[4*n +: 4];
    end

    // registered request interface
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            mem_rom    <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            mem_nib_en <= '1;
            err        <= 1'b0;
        end else begin
            mem_req <= step_en;
            err     <= use_hit && !dec.valid;
            if (step_en) begin
                mem_we     <= win_we;
                mem_rom    <= dec.rom;
                mem_addr   <= {cur_mode[HI_W-1:0], cur_addr, 1'b0};
                mem_wdata  <= win_wdata;
                mem_nib_en <= (win_we && dec.merge) ? nib_nz : '1;
            end
        end
    end
endmodule

// File: rtl/xwin_ctl_chk.sv
module xwin_ctl_chk
    import xwin_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         win_acc,
    input logic [2:0]   win_sel,
    input logic [1:0]   gp_stat,
    input logic         mem_req,
    input logic         mem_we,
    input logic         mem_rom,
    input logic [23:0]  mem_addr,
    input logic [15:0]  mem_wdata,
    input logic [3:0]   mem_nib_en,
    input logic         err,
    input prg_state_e   ctl_state
);
    assert_req_follows_access_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || err) |-> $past(win_acc));

    assert_arm_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && ctl_state == PRG_ARMED) |=> (!mem_req && !err));

    assert_back_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_acc |=> (ctl_state == PRG_IDLE));

    assert_gated_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && win_sel < 3'd4 && gp_stat == 2'b00 && ctl_state != PRG_ARMED)
        |=> (!mem_req && !err));

    assert_err_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);

    assert_rom_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rom) |-> !mem_we);

    assert_read_full_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_nib_en == 4'hF));

    assert_masked_nibble_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_nib_en[0] || mem_wdata[3:0]   == 4'h0) &&
                     (mem_nib_en[1] || mem_wdata[7:4]   == 4'h0) &&
                     (mem_nib_en[2] || mem_wdata[11:8]  == 4'h0) &&
                     (mem_nib_en[3] || mem_wdata[15:12] == 4'h0)));

    assert_byte_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));
endmodule

bind xwin_ctl xwin_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_acc    (win_acc),
    .win_sel    (win_sel),
    .gp_stat    (gp_stat),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rom    (mem_rom),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_nib_en (mem_nib_en),
    .err        (err),
    .ctl_state  (ctl_state)
);

// File: tb/xwin_ctl_tb_top.sv
module xwin_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_rd = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        win_acc = 1'b0;
    logic [2:0]  win_sel = '0;
    logic        win_we = 1'b0;
    logic [15:0] win_wdata = '0;
    logic [1:0]  gp_stat = '0;
    logic        mem_req, mem_we, mem_rom, err;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [3:0]  mem_nib_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    xwin_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .win_acc(win_acc), .win_sel(win_sel), .win_we(win_we), .win_wdata(win_wdata),
        .gp_stat(gp_stat),
        .mem_req(mem_req), .mem_we(mem_we), .mem_rom(mem_rom), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_nib_en(mem_nib_en), .err(err)
    );

    localparam logic [1:0] K_CW = 2'd0, K_CR = 2'd1, K_WA = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  sel;
        logic        we;
        logic [1:0]  gp;
        logic [15:0] data;
        logic        req;
        logic        rom;
        logic        err;
        logic [3:0]  nib;
        logic [23:0] addr;
        logic        cc;
        logic [15:0] ctl;
        logic [3:0]  rq;
    } vec_t;

    function automatic vec_t cw(input logic [15:0] d);
        return '{K_CW, 3'd4, 1'b0, 2'd0, d, 1'b0, 1'b0, 1'b0, 4'h0, 24'h0, 1'b0, 16'h0, 4'd2};
    endfunction
    function automatic vec_t cwc(input logic [15:0] d, input logic [15:0] c, input int r);
        return '{K_CW, 3'd4, 1'b0, 2'd0, d, 1'b0, 1'b0, 1'b0, 4'h0, 24'h0, 1'b1, c, 4'(r)};
    endfunction
    function automatic vec_t cr(input logic [15:0] c, input int r);
        return '{K_CR, 3'd4, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0, 4'h0, 24'h0, 1'b1, c, 4'(r)};
    endfunction
    function automatic vec_t armv(input logic [2:0] s, input logic w, input logic [1:0] g,
                                  input logic [15:0] c, input int r);
        return '{K_WA, s, w, g, 16'h1234, 1'b0, 1'b0, 1'b0, 4'h0, 24'h0, 1'b1, c, 4'(r)};
    endfunction
    function automatic vec_t acc(input logic [2:0] s, input logic w, input logic [1:0] g,
                                 input logic [15:0] d, input logic q, input logic ro,
                                 input logic e, input logic [3:0] nb, input logic [23:0] a,
                                 input logic [15:0] c, input int r);
        return '{K_WA, s, w, g, d, q, ro, e, nb, a, 1'b1, c, 4'(r)};
    endfunction

    localparam int NV = 73;
    localparam vec_t VEC [NV] = '{
        // R2 programming handshake, R3 arming, R4 +1 write, R11 readback
        cwc(16'h1000, 16'h0000, 2), cwc(16'h0818, 16'h1000, 2),
        armv(3'd4, 1'b1, 2'd0, 16'h1000, 3),
        acc(3'd4, 1'b1, 2'd0, 16'hABCD, 1, 0, 0, 4'hF, 24'h302000, 16'h1001, 4),
        acc(3'd4, 1'b1, 2'd0, 16'h0001, 1, 0, 0, 4'hF, 24'h302002, 16'h1002, 11),
        // R4 no-step write
        cw(16'h2000), cw(16'h0018), armv(3'd4, 1'b1, 2'd0, 16'h2000, 3),
        acc(3'd4, 1'b1, 2'd0, 16'h5555, 1, 0, 0, 4'hF, 24'h304000, 16'h2000, 4),
        acc(3'd4, 1'b1, 2'd0, 16'h5555, 1, 0, 0, 4'hF, 24'h304000, 16'h2000, 4),
        // R7 merge write
        cw(16'h0040), cw(16'h0418), armv(3'd4, 1'b1, 2'd0, 16'h0040, 3),
        acc(3'd4, 1'b1, 2'd0, 16'h0A00, 1, 0, 0, 4'h4, 24'h300080, 16'h0040, 7),
        acc(3'd4, 1'b1, 2'd0, 16'hF00F, 1, 0, 0, 4'h9, 24'h300080, 16'h0040, 7),
        // R8 cell stride
        cw(16'h0101), cw(16'h4018), armv(3'd4, 1'b1, 2'd0, 16'h0101, 3),
        acc(3'd4, 1'b1, 2'd0, 16'h1111, 1, 0, 0, 4'hF, 24'h300202, 16'h0120, 8),
        acc(3'd4, 1'b1, 2'd0, 16'h2222, 1, 0, 0, 4'hF, 24'h300240, 16'h0121, 8),
        acc(3'd4, 1'b1, 2'd0, 16'h3333, 1, 0, 0, 4'hF, 24'h300242, 16'h0140, 8),
        // R8 cell stride with merge
        cw(16'h0010), cw(16'h4418), armv(3'd4, 1'b1, 2'd0, 16'h0010, 3),
        acc(3'd4, 1'b1, 2'd0, 16'h00F0, 1, 0, 0, 4'h2, 24'h300020, 16'h0011, 8),
        acc(3'd4, 1'b1, 2'd0, 16'h0000, 1, 0, 0, 4'h0, 24'h300022, 16'h0030, 8),
        // R5 read +32
        cw(16'h0005), cw(16'h3018), armv(3'd4, 1'b0, 2'd0, 16'h0005, 3),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h30000A, 16'h0025, 5),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h30004A, 16'h0045, 5),
        // R5 read -16
        cw(16'h0100), cw(16'hA818), armv(3'd4, 1'b0, 2'd0, 16'h0100, 3),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h300200, 16'h00F0, 5),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h3001E0, 16'h00E0, 5),
        // R5 read -128 with wrap, R9 high address bits
        cw(16'h0050), cw(16'hB818), armv(3'd4, 1'b0, 2'd0, 16'h0050, 3),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h3000A0, 16'hFFD0, 5),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h31FFA0, 16'hFF50, 9),
        // R5 no-step read, R11 readback
        cw(16'h0700), cw(16'h0018), armv(3'd4, 1'b0, 2'd0, 16'h0700, 3),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h300E00, 16'h0700, 11),
        // R5 +1 read with wrap at 0xFFFF
        cw(16'hFFFF), cw(16'h0818), armv(3'd4, 1'b0, 2'd0, 16'hFFFF, 3),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h31FFFE, 16'h0000, 9),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 0, 0, 4'hF, 24'h300000, 16'h0001, 5),
        // R6 ROM read
        cw(16'h1234), cw(16'h0805), armv(3'd4, 1'b0, 2'd0, 16'h1234, 3),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 1, 0, 4'hF, 24'h0A2468, 16'h1235, 6),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 1, 0, 4'hF, 24'h0A246A, 16'h1236, 6),
        // R13 write setting kept while the read setting was replaced
        acc(3'd4, 1'b1, 2'd0, 16'h1000, 1, 0, 0, 4'h8, 24'h300060, 16'h0031, 13),
        // R10 gating of windows 0..3
        cw(16'h0008), cw(16'h0818), armv(3'd1, 1'b1, 2'd0, 16'h0008, 3),
        acc(3'd1, 1'b1, 2'd0, 16'h7777, 0, 0, 0, 4'h0, 24'h0, 16'h0008, 10),
        acc(3'd1, 1'b1, 2'd1, 16'h7777, 1, 0, 0, 4'hF, 24'h300010, 16'h0009, 10),
        acc(3'd1, 1'b1, 2'd2, 16'h7777, 1, 0, 0, 4'hF, 24'h300012, 16'h000A, 10),
        // R12 unknown mode
        cw(16'h0003), cw(16'h1234), armv(3'd2, 1'b0, 2'd1, 16'h0003, 3),
        acc(3'd2, 1'b0, 2'd1, 16'h0, 0, 0, 1, 4'h0, 24'h0, 16'h0003, 12),
        // R2 control reads advance without storing; err back to 0 (R12)
        cr(16'h1234, 2), cr(16'h0003, 2),
        armv(3'd3, 1'b1, 2'd0, 16'h0003, 3),
        // R3 access in HAVE_ADDR acts normally
        cwc(16'h0777, 16'h1234, 2),
        acc(3'd4, 1'b0, 2'd0, 16'h0, 1, 1, 0, 4'hF, 24'h0A246C, 16'h1237, 3),
        acc(3'd4, 1'b1, 2'd0, 16'h0000, 1, 0, 0, 4'h0, 24'h300062, 16'h0050, 8),
        // R12 never-programmed window 2 write setting (mode 0)
        acc(3'd2, 1'b1, 2'd1, 16'h0, 0, 0, 1, 4'h0, 24'h0, 16'h0000, 12)
    };

    task automatic fail_line(input int r, input string what, input logic [31:0] act,
                             input logic [31:0] exp);
        n_bad++;
        $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
    endtask

    task automatic apply(input vec_t v);
        logic bad;
        @(negedge clk);
        ctl_wr    = (v.kind == K_CW);
        ctl_rd    = (v.kind == K_CR);
        ctl_wdata = v.data;
        win_acc   = (v.kind == K_WA);
        win_sel   = v.sel;
        win_we    = v.we;
        win_wdata = v.data;
        gp_stat   = v.gp;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0; ctl_rd = 1'b0; win_acc = 1'b0;
        n_chk++;
        bad = 1'b0;
        if (mem_req !== v.req) begin
            fail_line(v.rq, "mem_req", 32'(mem_req), 32'(v.req)); bad = 1'b1;
        end
        if (!bad && err !== v.err) begin
            fail_line(v.rq, "err", 32'(err), 32'(v.err)); bad = 1'b1;
        end
        if (!bad && v.req && {mem_we, mem_rom} !== {v.we, v.rom}) begin
            fail_line(v.rq, "we/rom", 32'({mem_we, mem_rom}), 32'({v.we, v.rom})); bad = 1'b1;
        end
        if (!bad && v.req && mem_addr !== v.addr) begin
            fail_line(v.rq, "mem_addr", 32'(mem_addr), 32'(v.addr)); bad = 1'b1;
        end
        if (!bad && v.req && v.we && (mem_nib_en !== v.nib || mem_wdata !== v.data)) begin
            fail_line(v.rq, "nib_en/wdata", {12'h0, mem_nib_en, mem_wdata},
                      {12'h0, v.nib, v.data}); bad = 1'b1;
        end
        if (!bad && v.req && !v.we && mem_nib_en !== 4'hF) begin
            fail_line(v.rq, "read nib_en", 32'(mem_nib_en), 32'hF); bad = 1'b1;
        end
        if (!bad && v.cc && ctl_rdata !== v.ctl) begin
            fail_line(v.rq, "ctl_rdata", 32'(ctl_rdata), 32'(v.ctl));
        end
    endtask

    task automatic check_idle(input int r, input logic [15:0] exp_ctl);
        n_chk++;
        if (mem_req !== 1'b0 || err !== 1'b0 || ctl_rdata !== exp_ctl)
            fail_line(r, "idle outputs", {14'h0, mem_req, err, ctl_rdata}, {16'h0, exp_ctl});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_idle(1, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(1, 16'h0000);

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R12 error is a single-cycle pulse
        @(negedge clk);
        check_idle(12, 16'h0000);

        // R1 reset clears settings: window 4 read setting now mode 0 -> err
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_idle(1, 16'h0000);
        apply(acc(3'd4, 1'b0, 2'd0, 16'h0, 0, 0, 1, 4'h0, 24'h0, 16'h0000, 1));
        // R14 request appears exactly one clock after the access, not later
        apply(cw(16'h0020));
        apply(cw(16'h0818));
        apply(armv(3'd0, 1'b0, 2'd3, 16'h0020, 3));
        apply(acc(3'd0, 1'b0, 2'd3, 16'h0, 1, 0, 0, 4'hF, 24'h300040, 16'h0021, 14));
        @(negedge clk);
        check_idle(14, 16'h0021);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule